// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block is a host-side controller. It drives a complete chip-erase algorithm on a byte-wide flash device through a plain bus-master port. The port has a one-cycle write strobe, a one-cycle read strobe, an address, write data and read data. Read data is expected in the cycle after the read strobe. A separate output switches on the high programming voltage for the whole run.

A start pulse begins the run. The block first asks an external program routine, through a request/acknowledge handshake, to write every byte to 00h. It then issues one erase pulse and walks the addresses upward from zero to a configurable last address. At each address it sends an erase-verify command followed by a read. A byte that reads back as FFh moves the walk to the next address. Any other value applies another erase pulse and checks the same address again.

A single pulse counter covers the whole chip and is never reset between addresses. When that counter reaches the configured limit, the run stops with an error. Every run ends by restoring read mode and dropping the voltage enable. The outcome is held on sticky done and error flags until the next start.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset, busWr, busRd, vppEn, pgmReq, done and error are all 0.
- R2: A start pulse while idle gives, one cycle later, done=0, error=0, vppEn=1 and pgmReq=1. pgmReq stays high until pgmAck is seen, and no bus write occurs before pgmAck.
- R3: vppEn is 1 in every cycle in which busWr is 1.
- R4: An erase pulse is two consecutive bus writes of data 20h at address 0. The following write, of data A0h, comes exactly ERASE_WAIT+1 cycles after the second 20h write.
- R5: An erase-verify is a write of A0h with busAddr equal to the address under test. A read of that same address follows exactly VERIFY_WAIT+1 cycles later. busRdata is sampled in the cycle after the read strobe, and busWr and busRd are never high together.
- R6: Verification starts at address 0 and never moves backward. A read value of FFh advances the address by one with no new erase pulse, and the walk ends at LAST_ADDR.
- R7: A read value other than FFh adds one to a pulse count that is shared by all addresses and applies a new erase pulse. The total number of erase pulses is therefore the smallest count at which every byte from 0 to LAST_ADDR reads FFh.
- R8: If a verify fails when PULSE_LIMIT pulses have already been applied, the run ends with error=1. The count never reaches PULSE_LIMIT, and no more than PULSE_LIMIT pulses are issued.
- R9: Every run ends with exactly one write of 00h. vppEn is 0 from the next cycle, and done (on success) or error (on failure) is set and held until the next start.
- R10: done and error are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a chip erase |
| pgmAck | input | 1 | One-cycle acknowledge that all bytes are programmed to 00h |
| busRdata | input | 8 | Read data, valid the cycle after busRd |
| busWr | output | 1 | Bus write strobe |
| busRd | output | 1 | Bus read strobe |
| busAddr | output | AW | Bus address |
| busWdata | output | 8 | Bus write data / command byte |
| vppEn | output | 1 | Programming-voltage enable |
| pgmReq | output | 1 | Request to the external preconditioning routine |
| done | output | 1 | Sticky: erase finished and verified |
| error | output | 1 | Sticky: pulse limit hit before all bytes verified |

## Verification
The testbench replaces the flash with a model. In that model each byte reads FFh only once a chosen number of chip-wide pulses has been applied. Three directed patterns are used: every byte erasing on the first pulse, which exercises the pure address walk; only the last byte needing exactly the pulse limit, which confirms that reaching the limit on the final try still succeeds; and one byte needing one pulse more than the limit, which must give an error partway through the walk. Random thresholds, some of them zero, with random acknowledge delays then check that the single shared pulse count and the read count match a bench prediction. A bus monitor checks command gaps, address order and the voltage enable on every run.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRECOND,
    ST_ER_SETUP,
    ST_ER_GO,
    ST_ER_WAIT,
    ST_EV_CMD,
    ST_EV_WAIT,
    ST_EV_RD,
    ST_EV_CHK,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic clrPulse;
    logic incPulse;
    logic loadErase;
    logic loadVerify;
  } dpCtl_t;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_EVERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/chip_erase_dp.sv
module chip_erase_dp
  import chip_erase_pkg::*;
#(
  parameter int AW          = 18,
  parameter int LAST_ADDR   = (1 << AW) - 1,
  parameter int PULSE_LIMIT = 1000,
  parameter int ERASE_WAIT  = 1000000,
  parameter int VERIFY_WAIT = 600
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  output logic [AW-1:0] addr,
  output logic          lastAddr,
  output logic          limitNext,
  output logic          timerZero
);
  localparam int MAXW = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TW   = $clog2(MAXW + 1);
  localparam int PW   = $clog2(PULSE_LIMIT + 1);

  logic [PW-1:0] pulseCnt;
  logic [TW-1:0] timerCnt;

  // address walk
  always_ff @(posedge clk) begin
    if (!rstN)            addr <= '0;
    else if (ctl.clrAddr) addr <= '0;
    else if (ctl.incAddr) addr <= addr + 1'b1;
  end

  // chip-wide pulse counter
  always_ff @(posedge clk) begin
    if (!rstN)             pulseCnt <= '0;
    else if (ctl.clrPulse) pulseCnt <= '0;
    else if (ctl.incPulse) pulseCnt <= pulseCnt + 1'b1;
  end

  // shared down-counter for both waits
  always_ff @(posedge clk) begin
    if (!rstN)               timerCnt <= '0;
    else if (ctl.loadErase)  timerCnt <= TW'(ERASE_WAIT - 1);
    else if (ctl.loadVerify) timerCnt <= TW'(VERIFY_WAIT - 1);
    else if (timerCnt != '0) timerCnt <= timerCnt - 1'b1;
  end

  assign lastAddr  = (addr == AW'(LAST_ADDR));
  assign limitNext = (pulseCnt == PW'(PULSE_LIMIT - 1));
  assign timerZero = (timerCnt == '0);

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < PW'(PULSE_LIMIT)); // R8

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    addr <= AW'(LAST_ADDR)); // R6

endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
  import chip_erase_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          pgmAck,
  input  logic [7:0]    busRdata,
  input  logic [AW-1:0] addr,
  input  logic          lastAddr,
  input  logic          limitNext,
  input  logic          timerZero,
  output dpCtl_t        ctl,
  output logic          busWr,
  output logic          busRd,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  output logic          vppEn,
  output logic          pgmReq,
  output logic          done,
  output logic          error
);
  seqState_t state, nextState;
  logic failSeen, setFail;

  always_comb begin
    nextState = state;
    ctl       = '0;
    busWr     = 1'b0;
    busRd     = 1'b0;
    busAddr   = '0;
    busWdata  = CMD_READ;
    pgmReq    = 1'b0;
    setFail   = 1'b0;
    case (state)
      ST_IDLE:    if (start) nextState = ST_PRECOND;
      ST_PRECOND: begin
        pgmReq = 1'b1;
        if (pgmAck) begin
          ctl.clrAddr  = 1'b1;
          ctl.clrPulse = 1'b1;
          nextState    = ST_ER_SETUP;
        end
      end
      ST_ER_SETUP: begin
        busWr     = 1'b1;
        busWdata  = CMD_ERASE;
        nextState = ST_ER_GO;
      end
      ST_ER_GO: begin
        busWr         = 1'b1;
        busWdata      = CMD_ERASE;
        ctl.loadErase = 1'b1;
        nextState     = ST_ER_WAIT;
      end
      ST_ER_WAIT: if (timerZero) nextState = ST_EV_CMD;
      ST_EV_CMD: begin
        busWr          = 1'b1;
        busWdata       = CMD_EVERIFY;
        busAddr        = addr;
        ctl.loadVerify = 1'b1;
        nextState      = ST_EV_WAIT;
      end
      ST_EV_WAIT: if (timerZero) nextState = ST_EV_RD;
      ST_EV_RD: begin
        busRd     = 1'b1;
        busAddr   = addr;
        nextState = ST_EV_CHK;
      end
      ST_EV_CHK: begin
        if (busRdata == BYTE_ERASED) begin
          if (lastAddr) nextState = ST_FINISH;
          else begin
            ctl.incAddr = 1'b1;
            nextState   = ST_EV_CMD;
          end
        end else if (limitNext) begin
          setFail   = 1'b1;
          nextState = ST_FINISH;
        end else begin
          ctl.incPulse = 1'b1;
          nextState    = ST_ER_SETUP;
        end
      end
      ST_FINISH: begin
        busWr     = 1'b1;
        busWdata  = CMD_READ;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      vppEn    <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      failSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        vppEn    <= 1'b1;
        done     <= 1'b0;
        error    <= 1'b0;
        failSeen <= 1'b0;
      end
      if (setFail) failSeen <= 1'b1;
      if (state == ST_FINISH) begin
        vppEn <= 1'b0;
        done  <= !failSeen;
        error <= failSeen;
      end
    end
  end

  AST_VPP_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> vppEn); // R3

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd)); // R5

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R10

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> (!done && !error && vppEn && pgmReq)); // R2

  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(failSeen)); // R8

  AST_VPP_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |=> (!vppEn && (done || error))); // R9

endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import chip_erase_pkg::*;
#(
  parameter int AW          = 18,
  parameter int LAST_ADDR   = (1 << AW) - 1,
  parameter int PULSE_LIMIT = 1000,
  parameter int ERASE_WAIT  = 1000000,
  parameter int VERIFY_WAIT = 600
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          pgmAck,
  input  logic [7:0]    busRdata,
  output logic          busWr,
  output logic          busRd,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  output logic          vppEn,
  output logic          pgmReq,
  output logic          done,
  output logic          error
);
  dpCtl_t        ctl;
  logic [AW-1:0] addr;
  logic          lastAddr, limitNext, timerZero;

  chip_erase_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pgmAck(pgmAck), .busRdata(busRdata),
    .addr(addr), .lastAddr(lastAddr), .limitNext(limitNext), .timerZero(timerZero),
    .ctl(ctl), .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .vppEn(vppEn), .pgmReq(pgmReq), .done(done), .error(error)
  );

  chip_erase_dp #(
    .AW(AW), .LAST_ADDR(LAST_ADDR), .PULSE_LIMIT(PULSE_LIMIT),
    .ERASE_WAIT(ERASE_WAIT), .VERIFY_WAIT(VERIFY_WAIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr),
    .lastAddr(lastAddr), .limitNext(limitNext), .timerZero(timerZero)
  );

endmodule

// File: tb/chip_erase_seq_bench.sv
module chip_erase_seq_bench;
  localparam int AW    = 4;
  localparam int LAST  = 11;
  localparam int LIMIT = 6;
  localparam int EW    = 20;
  localparam int VW    = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic pgmAck = 1'b0;
  logic [7:0] busRdata = 8'h00;
  logic busWr, busRd, vppEn, pgmReq, done, error;
  logic [AW-1:0] busAddr;
  logic [7:0] busWdata;

  always #5 clk = ~clk;

  chip_erase_seq #(
    .AW(AW), .LAST_ADDR(LAST), .PULSE_LIMIT(LIMIT), .ERASE_WAIT(EW), .VERIFY_WAIT(VW)
  ) u_chip_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .pgmAck(pgmAck), .busRdata(busRdata),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .vppEn(vppEn), .pgmReq(pgmReq), .done(done), .error(error)
  );

  int checks = 0;
  int failures = 0;
  int need [DEPTH];

  // monitor / flash model state
  int cyc = 0;
  int pulses, reads, finWrites, gapErr, vppErr, orderErr, addrErr;
  int lastGoCyc, lastA0Cyc, verifyAddr, prevVerify;
  bit armed, afterGo, ackGiven;
  logic [7:0] lastWdata;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (busWr) begin
        lastWdata = busWdata;
        if (!vppEn) vppErr++;
        if (!ackGiven) orderErr++;
        if (busWdata == 8'h20) begin
          if (busAddr != '0) addrErr++;
          if (armed) begin
            pulses++; armed = 0; lastGoCyc = cyc; afterGo = 1;
          end else armed = 1;
        end else begin
          if (armed) orderErr++;
          armed = 0;
          if (busWdata == 8'hA0) begin
            if (afterGo && (cyc - lastGoCyc) != EW + 1) gapErr++;
            afterGo = 0;
            verifyAddr = int'(busAddr);
            if (prevVerify < 0 && verifyAddr != 0) addrErr++;
            if (verifyAddr < prevVerify) addrErr++;
            prevVerify = verifyAddr;
            lastA0Cyc = cyc;
          end else if (busWdata == 8'h00) finWrites++;
        end
      end
      if (busRd) begin
        reads++;
        if (int'(busAddr) != verifyAddr) addrErr++;
        if ((cyc - lastA0Cyc) != VW + 1) gapErr++;
        busRdata = (pulses >= need[busAddr]) ? 8'hFF : 8'h3C;
      end
    end
  end

  task automatic predict(output bit ok, output int expPulses, output int expReads);
    int applied = 1;
    ok = 1;
    expReads = 0;
    for (int a = 0; a <= LAST; a++) begin
      while (1) begin
        expReads++;
        if (need[a] <= applied) break;
        if (applied == LIMIT) begin
          ok = 0; expPulses = applied; return;
        end
        applied++;
      end
    end
    expPulses = applied;
  endtask

  task automatic runErase(input string tag);
    bit expOk;
    int expPulses, expReads, waitCyc, ackDelay;
    predict(expOk, expPulses, expReads);
    pulses = 0; reads = 0; finWrites = 0; gapErr = 0; vppErr = 0;
    orderErr = 0; addrErr = 0; armed = 0; afterGo = 0; ackGiven = 0;
    prevVerify = -1; verifyAddr = -1; lastGoCyc = 0; lastA0Cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: flags cleared, request raised
    check(!done && !error && vppEn && pgmReq, "R2", {tag, " start state"},
          {28'd0, done, error, vppEn, pgmReq}, 4'b0011);
    ackDelay = $urandom_range(0, 5);
    repeat (ackDelay) @(negedge clk);
    check(pgmReq == 1'b1, "R2", {tag, " req held"}, pgmReq, 1);
    ackGiven = 1; pgmAck = 1'b1;
    @(negedge clk); pgmAck = 1'b0;
    waitCyc = 0;
    while (!done && !error && waitCyc < 20000) begin
      @(negedge clk); waitCyc++;
    end
    check(done == expOk && error == !expOk, expOk ? "R9" : "R8", {tag, " outcome"},
          {done, error}, {expOk, !expOk});
    check(!(done && error), "R10", {tag, " flags exclusive"}, {done, error}, 2'b10);
    check(pulses == expPulses, "R7", {tag, " pulses"}, pulses, expPulses);
    check(pulses <= LIMIT, "R8", {tag, " pulse cap"}, pulses, LIMIT);
    check(reads == expReads, "R6", {tag, " verify reads"}, reads, expReads);
    check(addrErr == 0, "R6", {tag, " address order"}, addrErr, 0);
    check(gapErr == 0, "R4", {tag, " erase/verify gaps (R5)"}, gapErr, 0);
    check(vppErr == 0, "R3", {tag, " vpp on writes"}, vppErr, 0);
    check(orderErr == 0, "R2", {tag, " no write before ack"}, orderErr, 0);
    check(finWrites == 1 && lastWdata == 8'h00 && !vppEn, "R9", {tag, " finish"},
          finWrites * 2 + int'(vppEn), 2);
    repeat (3) @(negedge clk);
    check(done == expOk && error == !expOk, "R9", {tag, " sticky"},
          {done, error}, {expOk, !expOk});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    repeat (3) @(negedge clk);
    check(!busWr && !busRd && !vppEn && !pgmReq && !done && !error, "R1", "reset",
          {busWr, busRd, vppEn, pgmReq, done, error}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busWr && !busRd && !vppEn && !pgmReq && !done && !error, "R1", "idle after reset",
          {busWr, busRd, vppEn, pgmReq, done, error}, 0);

    // beyond LAST: never verified, would fail if walked
    for (int a = LAST + 1; a < DEPTH; a++) need[a] = 1000;

    // directed: all erase on first pulse
    for (int a = 0; a <= LAST; a++) need[a] = 1;
    runErase("allFirst");

    // directed: last byte needs exactly LIMIT pulses
    need[LAST] = LIMIT;
    runErase("lastAtLimit");

    // directed: one byte needs one pulse beyond LIMIT
    need[LAST] = 1;
    need[3] = LIMIT + 1;
    runErase("overLimit");

    // random thresholds
    for (int r = 0; r < 8; r++) begin
      for (int a = 0; a <= LAST; a++) begin
        need[a] = ($urandom_range(0, 9) == 0) ? LIMIT + 1 : int'($urandom_range(0, LIMIT));
      end
      runErase($sformatf("rand%0d", r));
    end
    finishRun();
  end

endmodule